// File: doc/BRIEF.md
# Layered LLR Update Engine

This block carries out one layer sub-iteration of layered soft decoding for a block-structured parity check code. It works on eight parallel lanes, one per check row of the layer, and keeps two on-chip stores: an a-posteriori (APP) store holding one soft word per lane for every block column, and an extrinsic store holding one soft word per lane for every layer and edge. Before a codeword is decoded, its channel LLRs are written column by column into the APP store. That load also makes every extrinsic entry read as zero.

When a layer is started, the engine walks the layer's edges in order. For each edge it reads the APP word of the column the edge touches and the extrinsic word last written for that layer and edge. It removes the old extrinsic from the APP value and streams the resulting temporary message to an external check processor. The check processor returns one new extrinsic word per edge, in the same order. For each returned word the engine writes the column's APP word as the temporary message plus the new extrinsic. One cycle later it writes the new extrinsic over the old one. A one-cycle done pulse follows the last write-back.

The code tables are not part of this block. A fixed edge list stands in for them: edge e of layer l touches block column (l + e) mod N_COLS. Because the APP store always holds current a-posteriori values, a later layer reads the results of an earlier one directly, and a full iteration is just one start per layer.

Top module: `llr_layer_engine`

## Requirements
- R1: A channel load (ld_en high while idle) writes column ld_col. Lane i takes the 8-bit signed value ld_llr[i*8 +: 8] with 2 fractional bits, sign-extended to the 10-bit internal word. While idle, rd_app shows the APP word of rd_col one cycle after rd_col is applied, with lane i at bits [i*10 +: 10].
- R2: After an accepted start, the engine emits exactly 3 temporary messages (cp_valid high for one cycle each), one for each of edges 0, 1, 2 in that order. Edge e of layer l uses column (l + e) mod 6, and cp_last is high only with the edge-2 message.
- R3: In each lane, a temporary message equals the column's APP value minus the extrinsic value last written for the same layer and edge since the last channel load.
- R4: New extrinsic words are taken from cp_ext in edge order. For each one, the column's APP word becomes the temporary message plus the new extrinsic, and that new extrinsic becomes the stored value for the layer and edge. The extrinsic write happens one cycle after the APP write.
- R5: Every addition and subtraction saturates to the signed 10-bit range [-512, 511] instead of wrapping.
- R6: The 8 lanes are computed independently of one another.
- R7: done is high for exactly one cycle, one cycle after the last extrinsic write of the layer. A start presented during that done cycle is accepted.
- R8: These have no effect: a start while a layer is in progress, a start with layer_idx of 4 or more, ld_en while a layer is in progress, and cp_ext_valid outside the phase in which the engine waits for new extrinsics.
- R9: A channel load makes every stored extrinsic value read as zero, so the first layer processed after a load emits temporary messages equal to the APP values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start one layer sub-iteration |
| layer_idx | input | 3 | Layer to process, valid 0 to 3 |
| done | output | 1 | One-cycle pulse after the layer's write-back |
| ld_en | input | 1 | Channel LLR write strobe (idle only) |
| ld_col | input | 3 | Block column being loaded |
| ld_llr | input | 64 | Eight 8-bit channel LLRs |
| rd_col | input | 3 | Column to read while idle |
| rd_app | output | 80 | Eight 10-bit APP values of rd_col |
| cp_valid | output | 1 | Temporary message valid |
| cp_last | output | 1 | Marks the final message of the layer |
| cp_tmsg | output | 80 | Eight 10-bit temporary messages |
| cp_ext_valid | input | 1 | New extrinsic word valid |
| cp_ext | input | 80 | Eight 10-bit new extrinsic values |

## Verification
The end of one layer and the start of the next can fall in the same cycle: the bench raises start in the very cycle it sees done. It then requires that the following layer emit messages built from the APP values the previous layer has just written back, and that done has already fallen. A second overlap places a stray start and a channel load in the same cycle that the engine accepts a new extrinsic word. That run is judged by checking that the layer completes with the expected values, that no second layer follows, and that the loaded column still holds its computed APP word.

// File: rtl/llr_eng_pkg.sv
package llr_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DRAIN
  } eng_state_e;
endpackage

// File: rtl/llr_mem.sv
// Simple dual-port store: one write port, one registered read port.
module llr_mem #(
  parameter int DW = 80,
  parameter int DEPTH = 6,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/llr_sat_arith.sv
// Saturating signed add or subtract of two W-bit words.
module llr_sat_arith #(
  parameter int W = 10,
  parameter bit SUB = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] wide;
  logic       b_sign_eff;

  always_comb begin
    if (SUB) wide = {a[W-1], a} - {b[W-1], b};
    else     wide = {a[W-1], a} + {b[W-1], b};
    if (wide[W] != wide[W-1])
      y = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      y = wide[W-1:0];
  end

  assign b_sign_eff = SUB ? ~b[W-1] : b[W-1];

  // R5
  always_comb begin
    if (!$isunknown({a, b})) begin
      sat_sign_chk: assert (!(a[W-1] == b_sign_eff && y[W-1] != a[W-1]));
    end
  end
endmodule

// File: rtl/llr_layer_engine.sv
module llr_layer_engine
  import llr_eng_pkg::*;
#(
  parameter int Z = 8,
  parameter int LLR_W = 8,
  parameter int INT_W = 10,
  parameter int N_COLS = 6,
  parameter int N_LAYERS = 4,
  parameter int DEG = 3,
  localparam int LIW = $clog2(N_LAYERS + 1),
  localparam int CW = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int VW = Z * INT_W,
  localparam int CHW = Z * LLR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [LIW-1:0] layer_idx,
  output logic           done,
  input  logic           ld_en,
  input  logic [CW-1:0]  ld_col,
  input  logic [CHW-1:0] ld_llr,
  input  logic [CW-1:0]  rd_col,
  output logic [VW-1:0]  rd_app,
  output logic           cp_valid,
  output logic           cp_last,
  output logic [VW-1:0]  cp_tmsg,
  input  logic           cp_ext_valid,
  input  logic [VW-1:0]  cp_ext
);
  localparam int LW = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1;
  localparam int DGW = (DEG > 1) ? $clog2(DEG) : 1;
  localparam int EDGES = N_LAYERS * DEG;
  localparam int EA = (EDGES > 1) ? $clog2(EDGES) : 1;

  // Fixed edge list: edge e of layer l touches column (l + e) mod N_COLS.
  function automatic logic [CW-1:0] col_of(input logic [LW-1:0] l, input logic [DGW-1:0] e);
    return CW'((int'(l) + int'(e)) % N_COLS);
  endfunction

  function automatic logic [EA-1:0] eaddr_of(input logic [LW-1:0] l, input logic [DGW-1:0] e);
    return EA'(int'(l) * DEG + int'(e));
  endfunction

  eng_state_e       state;
  logic [LW-1:0]    layer_q;
  logic [DGW-1:0]   rd_cnt;
  logic [DGW-1:0]   ex_cnt;
  logic             idle;
  logic             start_ok;
  logic             ld_ok;
  logic             ext_ok;

  // read-side pipeline
  logic             p1_v;
  logic [DGW-1:0]   p1_idx;
  // write-back pipeline
  logic             s1_v;
  logic [DGW-1:0]   s1_idx;
  logic [VW-1:0]    s1_enew;
  logic             s2_v;
  logic [DGW-1:0]   s2_idx;
  logic [VW-1:0]    s2_enew;

  logic [EDGES-1:0] ext_vld;
  logic             vld_q;

  logic [VW-1:0]    ld_ext;
  logic [VW-1:0]    app_rdata;
  logic [VW-1:0]    ext_rdata;
  logic [VW-1:0]    ext_masked;
  logic [VW-1:0]    tmp_rdata;
  logic [VW-1:0]    t_vec;
  logic [VW-1:0]    app_new;

  logic             app_we;
  logic [CW-1:0]    app_waddr;
  logic [VW-1:0]    app_wdata;
  logic [CW-1:0]    app_raddr;
  logic             app_eng_we;
  logic             ext_we;
  logic [EA-1:0]    ext_waddr;
  logic [EA-1:0]    ext_raddr;

  assign idle     = (state == ST_IDLE);
  assign start_ok = idle && start && (layer_idx < LIW'(N_LAYERS));
  assign ld_ok    = idle && ld_en;
  assign ext_ok   = (state == ST_WAIT) && cp_ext_valid;

  // Per-lane datapath: sign extension, old-extrinsic removal, APP update.
  generate
    for (genvar i = 0; i < Z; i++) begin : g_lane
      assign ld_ext[i*INT_W +: INT_W] =
        {{(INT_W-LLR_W){ld_llr[i*LLR_W+LLR_W-1]}}, ld_llr[i*LLR_W +: LLR_W]};

      llr_sat_arith #(.W(INT_W), .SUB(1'b1)) u_sub (
        .a(app_rdata[i*INT_W +: INT_W]),
        .b(ext_masked[i*INT_W +: INT_W]),
        .y(t_vec[i*INT_W +: INT_W])
      );

      llr_sat_arith #(.W(INT_W), .SUB(1'b0)) u_add (
        .a(tmp_rdata[i*INT_W +: INT_W]),
        .b(s1_enew[i*INT_W +: INT_W]),
        .y(app_new[i*INT_W +: INT_W])
      );
    end
  endgenerate

  // APP store: channel load while idle, engine write-back otherwise.
  assign app_eng_we = s1_v;
  assign app_we     = ld_ok || app_eng_we;
  assign app_waddr  = app_eng_we ? col_of(layer_q, s1_idx) : ld_col;
  assign app_wdata  = app_eng_we ? app_new : ld_ext;
  assign app_raddr  = idle ? rd_col : col_of(layer_q, rd_cnt);

  llr_mem #(.DW(VW), .DEPTH(N_COLS)) u_app_mem (
    .clk(clk), .we(app_we), .waddr(app_waddr), .wdata(app_wdata),
    .raddr(app_raddr), .rdata(app_rdata)
  );

  assign rd_app = app_rdata;

  // Extrinsic store, one entry per layer and edge.
  assign ext_we    = s2_v;
  assign ext_waddr = eaddr_of(layer_q, s2_idx);
  assign ext_raddr = eaddr_of(layer_q, rd_cnt);

  llr_mem #(.DW(VW), .DEPTH(EDGES)) u_ext_mem (
    .clk(clk), .we(ext_we), .waddr(ext_waddr), .wdata(s2_enew),
    .raddr(ext_raddr), .rdata(ext_rdata)
  );

  // Entry valid flags: a channel load makes every entry read as zero.
  always_ff @(posedge clk) begin
    if (rst || ld_ok) ext_vld <= '0;
    else if (ext_we) ext_vld[ext_waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    vld_q <= ext_vld[ext_raddr];
  end

  assign ext_masked = vld_q ? ext_rdata : '0;

  // Temporary messages held until their new extrinsic returns.
  llr_mem #(.DW(VW), .DEPTH(DEG)) u_tmp_mem (
    .clk(clk), .we(p1_v), .waddr(p1_idx), .wdata(t_vec),
    .raddr(ex_cnt), .rdata(tmp_rdata)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      layer_q <= '0;
      rd_cnt  <= '0;
      ex_cnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            layer_q <= layer_idx[LW-1:0];
            rd_cnt  <= '0;
            state   <= ST_READ;
          end
        end
        ST_READ: begin
          rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt == DGW'(DEG - 1)) begin
            ex_cnt <= '0;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cp_ext_valid) begin
            ex_cnt <= ex_cnt + 1'b1;
            if (ex_cnt == DGW'(DEG - 1)) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (s2_v && s2_idx == DGW'(DEG - 1)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read pipeline and registered stream to the check processor.
  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v     <= 1'b0;
      p1_idx   <= '0;
      cp_valid <= 1'b0;
      cp_last  <= 1'b0;
    end else begin
      p1_v     <= (state == ST_READ);
      p1_idx   <= rd_cnt;
      cp_valid <= p1_v;
      cp_last  <= p1_v && (p1_idx == DGW'(DEG - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (p1_v) cp_tmsg <= t_vec;
  end

  // Write-back pipeline: APP write at stage 1, extrinsic write at stage 2.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_idx <= '0;
      s2_v   <= 1'b0;
      s2_idx <= '0;
    end else begin
      s1_v   <= ext_ok;
      s1_idx <= ex_cnt;
      s2_v   <= s1_v;
      s2_idx <= s1_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (ext_ok) s1_enew <= cp_ext;
    s2_enew <= s1_enew;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_after_ext_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(ext_we));
  // R4
  ext_after_app_chk: assert property (@(posedge clk) disable iff (rst) ext_we |-> $past(app_eng_we));
  // R2
  cp_last_chk: assert property (@(posedge clk) disable iff (rst) cp_last |-> cp_valid);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && start) |=> (layer_q == $past(layer_q)));
endmodule

// File: tb/llr_layer_engine_test.sv
module llr_layer_engine_test;
  localparam int Z = 8;
  localparam int LW8 = 8;
  localparam int IW = 10;
  localparam int NC = 6;
  localparam int NL = 4;
  localparam int DG = 3;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [2:0] layer_idx;
  logic done;
  logic ld_en;
  logic [2:0] ld_col;
  logic [Z*LW8-1:0] ld_llr;
  logic [2:0] rd_col;
  logic [Z*IW-1:0] rd_app;
  logic cp_valid, cp_last;
  logic [Z*IW-1:0] cp_tmsg;
  logic cp_ext_valid;
  logic [Z*IW-1:0] cp_ext;

  llr_layer_engine uut (
    .clk(clk), .rst(rst), .start(start), .layer_idx(layer_idx), .done(done),
    .ld_en(ld_en), .ld_col(ld_col), .ld_llr(ld_llr), .rd_col(rd_col),
    .rd_app(rd_app), .cp_valid(cp_valid), .cp_last(cp_last), .cp_tmsg(cp_tmsg),
    .cp_ext_valid(cp_ext_valid), .cp_ext(cp_ext)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int pass_n = 0;
  int app_m [NC][Z];
  int ext_m [NL][DG][Z];
  int ldv [Z];
  int expv [Z];
  int tq [DG][Z];
  int en [DG][Z];

  function automatic int sat(input int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int lane_of(input logic [Z*IW-1:0] v, input int i);
    return int'($signed(v[i*IW +: IW]));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_lanes(input logic [Z*IW-1:0] v, input string req, input string what);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < Z; i++)
      if (bad_i < 0 && lane_of(v, i) != expv[i]) bad_i = i;
    if (bad_i < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s lane %0d", what, bad_i), lane_of(v, bad_i), expv[bad_i]);
  endtask

  task automatic load_col(input int c);
    ld_en = 1'b1;
    ld_col = 3'(c);
    for (int i = 0; i < Z; i++) ld_llr[i*LW8 +: LW8] = 8'(ldv[i]);
    @(negedge clk);
    ld_en = 1'b0;
    for (int i = 0; i < Z; i++) app_m[c][i] = ldv[i];
    for (int l = 0; l < NL; l++)
      for (int e = 0; e < DG; e++)
        for (int i = 0; i < Z; i++) ext_m[l][e][i] = 0;
  endtask

  task automatic load_all(input int seed);
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < Z; i++) ldv[i] = ((c * 37 + i * 11 + seed * 5) % 255) - 127;
      load_col(c);
    end
  endtask

  task automatic check_cols(input string req);
    for (int c = 0; c < NC; c++) begin
      rd_col = 3'(c);
      @(negedge clk);
      for (int i = 0; i < Z; i++) expv[i] = app_m[c][i];
      chk_lanes(rd_app, req, $sformatf("APP column %0d", c));
    end
  endtask

  task automatic run_layer(input int l, input bit use_const, input int v0, input int v1,
                           input int v2, input bit inject, input string req);
    int got;
    int k;
    int c;
    got = 0;
    start = 1'b1;
    layer_idx = 3'(l);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7", "done pulse width", int'(done), 0);
    for (int kk = 0; kk < 30 && got < DG; kk++) begin
      if (cp_valid) begin
        c = (l + got) % NC;
        for (int i = 0; i < Z; i++) begin
          expv[i] = sat(app_m[c][i] - ext_m[l][got][i]);
          tq[got][i] = expv[i];
        end
        chk_lanes(cp_tmsg, req, $sformatf("temporary message layer %0d edge %0d", l, got));
        chk(cp_last == (got == DG - 1), "R2", "last flag", int'(cp_last), int'(got == DG - 1));
        got++;
      end
      @(negedge clk);
    end
    chk(got == DG, "R2", "temporary message count", got, DG);
    for (int e = 0; e < DG; e++) begin
      for (int i = 0; i < Z; i++) begin
        if (use_const) en[e][i] = (e == 0) ? v0 : ((e == 1) ? v1 : v2);
        else en[e][i] = ((pass_n * 7 + l * 13 + e * 5 + i * 3) % 41) - 20;
        cp_ext[i*IW +: IW] = 10'(en[e][i]);
      end
      cp_ext_valid = 1'b1;
      if (inject && e == 0) begin
        start = 1'b1;
        layer_idx = 3'((l + 1) % NL);
        ld_en = 1'b1;
        ld_col = 3'(l % NC);
        ld_llr = {Z{8'h55}};
      end
      @(negedge clk);
      start = 1'b0;
      ld_en = 1'b0;
    end
    cp_ext_valid = 1'b0;
    for (int e = 0; e < DG; e++) begin
      c = (l + e) % NC;
      for (int i = 0; i < Z; i++) begin
        app_m[c][i] = sat(tq[e][i] + en[e][i]);
        ext_m[l][e][i] = en[e][i];
      end
    end
    k = 0;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(done == 1'b1, "R7", "done after write-back", int'(done), 1);
    pass_n++;
  endtask

  task automatic quiet_window(input string req, input string what);
    int seen;
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cp_valid) seen++;
    end
    chk(seen == 0, req, what, seen, 0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R7", "done after reset", int'(done), 0);
    chk(cp_valid == 1'b0, "R2", "cp_valid after reset", int'(cp_valid), 0);
    chk(cp_last == 1'b0, "R2", "cp_last after reset", int'(cp_last), 0);
  endtask

  task automatic t_load;
    load_all(1);
    check_cols("R1");
  endtask

  task automatic t_first_layer;
    run_layer(0, 1'b0, 0, 0, 0, 1'b0, "R2");
    check_cols("R4");
  endtask

  task automatic t_chain;
    run_layer(1, 1'b0, 0, 0, 0, 1'b0, "R3");
    run_layer(2, 1'b0, 0, 0, 0, 1'b0, "R3");
    run_layer(3, 1'b0, 0, 0, 0, 1'b0, "R3");
    run_layer(0, 1'b0, 0, 0, 0, 1'b0, "R3");
    run_layer(1, 1'b0, 0, 0, 0, 1'b0, "R3");
    check_cols("R6");
  endtask

  task automatic t_ignore;
    for (int k = 0; k < 3; k++) begin
      cp_ext_valid = 1'b1;
      cp_ext = {Z{10'h1F0}};
      @(negedge clk);
    end
    cp_ext_valid = 1'b0;
    check_cols("R8");
    start = 1'b1;
    layer_idx = 3'd5;
    @(negedge clk);
    start = 1'b0;
    quiet_window("R8", "stream after out-of-range start");
    run_layer(2, 1'b0, 0, 0, 0, 1'b1, "R8");
    quiet_window("R8", "stream after busy start");
    check_cols("R8");
    run_layer(3, 1'b0, 0, 0, 0, 1'b0, "R8");
  endtask

  task automatic t_sat;
    load_all(7);
    for (int i = 0; i < Z; i++) ldv[i] = 127;
    load_col(0);
    for (int i = 0; i < Z; i++) ldv[i] = -128;
    load_col(1);
    for (int i = 0; i < Z; i++) ldv[i] = 100;
    load_col(2);
    run_layer(0, 1'b1, 500, -500, -500, 1'b0, "R5");
    run_layer(1, 1'b1, 0, 511, 0, 1'b0, "R5");
    run_layer(2, 1'b1, 511, 0, 0, 1'b0, "R5");
    run_layer(0, 1'b1, 0, 0, 0, 1'b0, "R5");
    check_cols("R5");
  endtask

  task automatic t_reload;
    load_all(11);
    run_layer(1, 1'b0, 0, 0, 0, 1'b0, "R9");
    run_layer(0, 1'b0, 0, 0, 0, 1'b0, "R9");
    check_cols("R9");
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    layer_idx = '0;
    ld_en = 1'b0;
    ld_col = '0;
    ld_llr = '0;
    rd_col = '0;
    cp_ext_valid = 1'b0;
    cp_ext = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_load;
    t_first_layer;
    t_chain;
    t_ignore;
    t_sat;
    t_reload;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1 (run completed)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule